// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block serializes parallel words onto one asynchronous line. It has two storage stages: a holding register that the bus side writes, and a shift register that drives the line. While one frame is on the line, the next word can wait in the holding register. An external bit-rate enable sets the timing. The block itself never counts baud periods: every line transition happens on a clock edge where that enable is high.

The frame format is chosen with a set of static controls:
- 7, 8 or 9 data bits.
- An optional parity bit, even or odd, or a multiprocessor address/data flag in the same position.
- One or two stop bits.

A clear-to-send input can hold back each handoff from the holding register to the shift register. Checking that input can also be switched off.

There are two interrupt outputs. The buffer-empty request tells software it may write the next word. The transmission-end request tells it the line has gone idle. The holding register is checked again as the first stop bit begins. If a word is waiting at that point, frames run back to back with no idle time between them.

Top module: `async_tx_engine`

## Requirements
- R1: After reset, `txd_o` is 1, `tend_o` is 1, `full_o` is 0 and `irq_empty_o` is 0.
- R2: Bit order and timing:
  - A frame is sent as start bit (0), then the data bits least significant first, then the optional parity/flag bit, then the stop bits (1).
  - Each bit lasts exactly one bit-enable interval.
  - `fmt_i` selects the data width: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits, and 3 behaves as 8. Holding-register bits above the selected width are not sent.
- R3: With `par_en_i`=1 and `mp_mode_i`=0, a parity bit follows the data. It is computed over the sent data bits only: even parity when `par_odd_i`=0, odd parity when `par_odd_i`=1.
- R4: With `mp_mode_i`=1, the bit after the data carries `mp_flag_i`, whatever `par_en_i` is set to.
- R5: `two_stop_i`=1 sends two stop bits; `two_stop_i`=0 sends one.
- R6: A write of the high half takes `wr_data_i[0]` as data bit 8 and leaves `full_o` unchanged. Only a write of the low half marks the holding register as holding new data.
- R7: A word moves from the holding register to the shift register only when `cts_chk_i`=0 or `cts_n_i`=0. While the move is blocked, the line stays high and `full_o` stays 1.
- R8: `irq_empty_o` pulses for one cycle in two cases, provided `empty_ie_i`=1:
  - after each transfer from the holding register to the shift register;
  - after `tx_en_i` rises, including when `tx_en_i` and `empty_ie_i` rise in the same cycle.
- R9: If the holding register holds new data when the first stop bit begins, or receives a low-half write in that same cycle, the next start bit follows the last stop bit with no idle interval.
- R10: End of transmission:
  - `tend_o` is set when the first stop bit begins and the holding register holds no new data.
  - A low-half write clears `tend_o`. A write in the cycle the stop bit begins takes priority over setting it.
  - `irq_end_o` is `tend_o` gated by `end_ie_i`.
- R11: While `tx_en_i`=0, any frame in progress is abandoned, `txd_o` is held at 1 and `tend_o` is set, even if the holding register has data.
- R12: `full_o` rises in the cycle after a low-half write and falls in the cycle after the word is transferred to the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle bit-rate enable |
| tx_en_i | input | 1 | Transmitter enable |
| empty_ie_i | input | 1 | Buffer-empty interrupt enable |
| end_ie_i | input | 1 | Transmission-end interrupt enable |
| cts_chk_i | input | 1 | Enable clear-to-send gating |
| cts_n_i | input | 1 | Clear-to-send, active low |
| fmt_i | input | 2 | Data width select (0:7, 1:8, 2:9) |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | Odd parity select |
| mp_mode_i | input | 1 | Multiprocessor bit mode |
| mp_flag_i | input | 1 | Multiprocessor ID/data flag value |
| two_stop_i | input | 1 | Two stop bits |
| wr_lo_i | input | 1 | Write strobe, holding register bits 7:0 |
| wr_hi_i | input | 1 | Write strobe, holding register bit 8 |
| wr_data_i | input | 8 | Write data |
| txd_o | output | 1 | Serial line |
| full_o | output | 1 | Holding register has unsent data |
| tend_o | output | 1 | Transmission-end flag |
| irq_empty_o | output | 1 | Buffer-empty interrupt pulse |
| irq_end_o | output | 1 | Transmission-end interrupt |

## Verification
The sharpest collision is a low-half write arriving on the same clock edge that begins the first stop bit. At that edge the stop check sees an empty holding register, yet new data is landing. The bench times the write to the bit-enable cycle that ends the last data bit. It then expects `tend_o` to stay 0 during the stop bit and the next start bit to follow that stop bit directly. A lost write or a wrongly set end flag would instead show up as an idle interval or a raised `tend_o`.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  localparam int DATA_MAX  = 9;
  localparam int STOP_MAX  = 2;
  localparam int FRAME_MAX = 1 + DATA_MAX + 1 + STOP_MAX;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {
    FMT_7   = 2'd0,
    FMT_8   = 2'd1,
    FMT_9   = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  typedef logic [FRAME_MAX-1:0] frame_t;
endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold
  import async_tx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [7:0]          wr_data_i,
  input  logic                load_i,
  output logic [DATA_MAX-1:0] hold_o,
  output logic                full_o
);
  logic [DATA_MAX-1:0] hold_q;
  logic                full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_hi_i) hold_q[DATA_MAX-1] <= wr_data_i[0];
      if (wr_lo_i) hold_q[7:0] <= wr_data_i;
      // new write wins over a same-cycle transfer
      if (wr_lo_i)     full_q <= 1'b1;
      else if (load_i) full_q <= 1'b0;
    end
  end

  assign hold_o = hold_q;
  assign full_o = full_q;

  assert_full_set_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> full_o);
  assert_full_drop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_lo_i) |=> !full_o);
endmodule

// File: rtl/async_tx_frame.sv
module async_tx_frame
  import async_tx_pkg::*;
(
  input  logic [DATA_MAX-1:0] hold_i,
  input  logic [1:0]          fmt_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                mp_mode_i,
  input  logic                mp_flag_i,
  input  logic                two_stop_i,
  output frame_t              frame_o,
  output logic [CNT_W-1:0]    len_o,
  output logic [1:0]          nstop_o
);
  logic [CNT_W-1:0] nd;
  logic             has_pb;
  logic             par;

  always_comb begin
    unique case (fmt_e'(fmt_i))
      FMT_7:   nd = CNT_W'(7);
      FMT_9:   nd = CNT_W'(9);
      default: nd = CNT_W'(8);
    endcase
    has_pb  = par_en_i | mp_mode_i;
    nstop_o = two_stop_i ? 2'd2 : 2'd1;
    frame_o = '1;
    frame_o[0] = 1'b0;
    par = par_odd_i;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < int'(nd)) begin
        frame_o[1+i] = hold_i[i];
        par = par ^ hold_i[i];
      end
    end
    if (has_pb) frame_o[int'(nd)+1] = mp_mode_i ? mp_flag_i : par;
    len_o = CNT_W'(1) + nd + CNT_W'(has_pb) + CNT_W'(nstop_o);
  end
endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter
  import async_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             tx_en_i,
  input  logic             full_i,
  input  logic             cts_ok_i,
  input  logic             wr_lo_i,
  input  frame_t           frame_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [1:0]       nstop_i,
  output logic             load_o,
  output logic             txd_o,
  output logic             tend_o
);
  logic             busy_q;
  frame_t           shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       nstop_q;
  logic             tend_q;
  logic             last_bit;
  logic [CNT_W-1:0] cnt_dec;

  always_comb begin
    last_bit = busy_q && (cnt_q == CNT_W'(1));
    cnt_dec  = cnt_q - CNT_W'(1);
    load_o   = bit_en_i && tx_en_i && full_i && cts_ok_i && (!busy_q || last_bit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      shreg_q <= '1;
      cnt_q   <= '0;
      nstop_q <= 2'd1;
      tend_q  <= 1'b1;
    end else if (!tx_en_i) begin
      busy_q  <= 1'b0;
      shreg_q <= '1;
      cnt_q   <= '0;
      tend_q  <= 1'b1;
    end else begin
      if (wr_lo_i) tend_q <= 1'b0;
      if (load_o) begin
        busy_q  <= 1'b1;
        shreg_q <= frame_i;
        cnt_q   <= len_i;
        nstop_q <= nstop_i;
      end else if (bit_en_i && busy_q) begin
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          shreg_q <= {1'b1, shreg_q[FRAME_MAX-1:1]};
          cnt_q   <= cnt_dec;
          // first stop bit begins: empty holding register ends transmission
          if (cnt_dec == CNT_W'(nstop_q) && !full_i && !wr_lo_i) tend_q <= 1'b1;
        end
      end
    end
  end

  assign txd_o  = busy_q ? shreg_q[0] : 1'b1;
  assign tend_o = tend_q;

  assert_off_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (txd_o && tend_o));
  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !txd_o);
  assert_write_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && wr_lo_i) |=> !tend_o);
endmodule

// File: rtl/async_tx_engine.sv
module async_tx_engine
  import async_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       tx_en_i,
  input  logic       empty_ie_i,
  input  logic       end_ie_i,
  input  logic       cts_chk_i,
  input  logic       cts_n_i,
  input  logic [1:0] fmt_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       mp_mode_i,
  input  logic       mp_flag_i,
  input  logic       two_stop_i,
  input  logic       wr_lo_i,
  input  logic       wr_hi_i,
  input  logic [7:0] wr_data_i,
  output logic       txd_o,
  output logic       full_o,
  output logic       tend_o,
  output logic       irq_empty_o,
  output logic       irq_end_o
);
  logic [DATA_MAX-1:0] hold;
  frame_t              frame;
  logic [CNT_W-1:0]    len;
  logic [1:0]          nstop;
  logic                load;
  logic                cts_ok;
  logic                tx_en_q;
  logic                irq_empty_q;

  assign cts_ok = !cts_chk_i || !cts_n_i;

  async_tx_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (wr_lo_i),
    .wr_hi_i   (wr_hi_i),
    .wr_data_i (wr_data_i),
    .load_i    (load),
    .hold_o    (hold),
    .full_o    (full_o)
  );

  async_tx_frame u_frame (
    .hold_i     (hold),
    .fmt_i      (fmt_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .mp_mode_i  (mp_mode_i),
    .mp_flag_i  (mp_flag_i),
    .two_stop_i (two_stop_i),
    .frame_o    (frame),
    .len_o      (len),
    .nstop_o    (nstop)
  );

  async_tx_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .tx_en_i  (tx_en_i),
    .full_i   (full_o),
    .cts_ok_i (cts_ok),
    .wr_lo_i  (wr_lo_i),
    .frame_i  (frame),
    .len_i    (len),
    .nstop_i  (nstop),
    .load_o   (load),
    .txd_o    (txd_o),
    .tend_o   (tend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q     <= 1'b0;
      irq_empty_q <= 1'b0;
    end else begin
      tx_en_q     <= tx_en_i;
      irq_empty_q <= empty_ie_i && ((tx_en_i && !tx_en_q) || load);
    end
  end

  assign irq_empty_o = irq_empty_q;
  assign irq_end_o   = tend_o && end_ie_i;

  assert_cts_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> (!cts_chk_i || !cts_n_i));
  assert_empty_irq_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_empty_o |-> $past(empty_ie_i));
endmodule

// File: tb/async_tx_engine_bench.sv
module async_tx_engine_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       bit_en;
  logic       tx_en = 0, empty_ie = 0, end_ie = 0, cts_chk = 0, cts_n = 1;
  logic [1:0] fmt = 2'd1;
  logic       par_en = 0, par_odd = 0, mp_mode = 0, mp_flag = 0, two_stop = 0;
  logic       wr_lo_s = 0, wr_hi_s = 0;
  logic [7:0] wr_data = '0;
  logic       txd, full, tend, irq_empty, irq_end;

  int total = 0, fails = 0, irq_cnt = 0, div_cnt = 0;
  bit done = 0;

  async_tx_engine u_async_tx_engine (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .tx_en_i(tx_en),
    .empty_ie_i(empty_ie), .end_ie_i(end_ie), .cts_chk_i(cts_chk), .cts_n_i(cts_n),
    .fmt_i(fmt), .par_en_i(par_en), .par_odd_i(par_odd), .mp_mode_i(mp_mode),
    .mp_flag_i(mp_flag), .two_stop_i(two_stop), .wr_lo_i(wr_lo_s), .wr_hi_i(wr_hi_s),
    .wr_data_i(wr_data), .txd_o(txd), .full_o(full), .tend_o(tend),
    .irq_empty_o(irq_empty), .irq_end_o(irq_end)
  );

  always @(posedge clk) begin
    if (!rst_ni) begin
      div_cnt <= 0;
      bit_en  <= 1'b0;
    end else begin
      div_cnt <= (div_cnt == 3) ? 0 : div_cnt + 1;
      bit_en  <= (div_cnt == 3);
    end
  end

  always @(posedge clk) if (rst_ni && irq_empty) irq_cnt <= irq_cnt + 1;

  // {fmt, par_en, odd, mp, flag, two_stop, data[8:0], expected frame[12:0], length}
  localparam logic [32:0] VEC [0:5] = '{
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5, 13'h034A, 4'd10},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h05A, 13'h02B4, 4'd10},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 9'h001, 13'h0C02, 4'd12},
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'h1C3, 13'h0F86, 4'd12},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0FF, 13'h05FE, 4'd11},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h080, 13'h0300, 4'd10}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_lo(input logic [7:0] d);
    @(negedge clk); wr_data = d; wr_lo_s = 1'b1;
    @(negedge clk); wr_lo_s = 1'b0;
  endtask

  task automatic wr_hi(input logic b);
    @(negedge clk); wr_data = {7'd0, b}; wr_hi_s = 1'b1;
    @(negedge clk); wr_hi_s = 1'b0;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!(bit_en && !txd));
  endtask

  task automatic next_bit();
    do @(negedge clk); while (!bit_en);
  endtask

  task automatic cap(input int n, output logic [31:0] b);
    b = '0;
    wait_start();
    b[0] = txd;
    for (int i = 1; i < n; i++) begin
      next_bit();
      b[i] = txd;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] b, exp, mask;
    logic [32:0] v;
    int ic;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(tend == 1'b1, "R1 tend", tend, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(irq_empty == 1'b0, "R1 irq_empty", irq_empty, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R8: enable and interrupt enable set together
    tx_en = 1; empty_ie = 1; end_ie = 1;
    repeat (3) @(negedge clk);
    chk(irq_cnt == 1, "R8 enable rise irq", irq_cnt, 1);

    // R12 full set, R2 basic frame, R8 transfer irq, R10 end flag
    wr_lo(8'h3C);
    chk(full == 1'b1, "R12 full after write", full, 1);
    cap(10, b);
    chk(b[9:0] == 10'h278, "R2 frame 3C", b, 32'h278);
    chk(full == 1'b0, "R12 full after transfer", full, 0);
    chk(irq_cnt == 2, "R8 transfer irq", irq_cnt, 2);
    chk(tend && irq_end, "R10 end flag and irq", {tend, irq_end}, 2'b11);

    // vector table: R2 R3 R4 R5
    for (int k = 0; k < 6; k++) begin
      v = VEC[k];
      @(negedge clk);
      fmt = v[32:31]; par_en = v[30]; par_odd = v[29]; mp_mode = v[28];
      mp_flag = v[27]; two_stop = v[26];
      wr_hi(v[25]);
      wr_lo(v[24:17]);
      cap(int'(v[3:0]), b);
      mask = (32'd1 << v[3:0]) - 1;
      exp = {19'd0, v[16:4]};
      chk((b & mask) == exp, "R2/R3/R4/R5 frame vector", b & mask, exp);
      repeat (2) @(negedge clk);
    end
    fmt = 2'd1; par_en = 0; par_odd = 0; mp_mode = 0; mp_flag = 0; two_stop = 0;

    // R6 high half does not mark data present
    fmt = 2'd2;
    wr_hi(1'b1);
    chk(full == 1'b0, "R6 high write no full", full, 0);
    wr_lo(8'h00);
    cap(11, b);
    chk(b[10:0] == 11'h600, "R6 nine-bit frame", b[10:0], 32'h600);
    fmt = 2'd1;
    repeat (4) @(negedge clk);

    // R7 clear-to-send gating
    cts_chk = 1; cts_n = 1;
    wr_lo(8'h55);
    repeat (24) @(negedge clk);
    chk(txd == 1'b1 && full == 1'b1, "R7 blocked", {txd, full}, 2'b11);
    cts_n = 0;
    cap(10, b);
    chk(b[9:0] == 10'h2AA, "R7 released frame", b[9:0], 32'h2AA);
    cts_chk = 0; cts_n = 1;
    wr_lo(8'h0F);
    cap(10, b);
    chk(b[9:0] == 10'h21E, "R7 gating off frame", b[9:0], 32'h21E);
    repeat (4) @(negedge clk);

    // R10 write clears end flag
    wr_lo(8'h81);
    chk(tend == 1'b0 && irq_end == 1'b0, "R10 write clears", {tend, irq_end}, 0);
    cap(10, b);
    repeat (4) @(negedge clk);

    // R9 back-to-back frames
    ic = irq_cnt;
    wr_lo(8'h12);
    do @(negedge clk); while (full);
    wr_lo(8'hE7);
    cap(20, b);
    exp = 32'h224 | (32'h3CE << 10);
    chk(b[19:0] == exp[19:0], "R9 back-to-back", b[19:0], exp);
    chk(irq_cnt == ic + 2, "R8 two transfers", irq_cnt, ic + 2);
    repeat (6) @(negedge clk);

    // R9/R10 write in the cycle the stop bit begins
    wr_lo(8'h33);
    wait_start();
    for (int i = 1; i <= 8; i++) next_bit();
    wr_data = 8'hC4; wr_lo_s = 1'b1;
    @(negedge clk); wr_lo_s = 1'b0;
    chk(tend == 1'b0, "R10 collide no end flag", tend, 0);
    next_bit();
    chk(txd == 1'b1, "R9 collide stop bit", txd, 1);
    next_bit();
    chk(txd == 1'b0, "R9 collide next start no gap", txd, 0);
    b = '0;
    for (int i = 1; i < 10; i++) begin
      next_bit();
      b[i] = txd;
    end
    chk(b[9:0] == 10'h388, "R9 collide second frame", b[9:0], 32'h388);
    repeat (4) @(negedge clk);

    // R11 abort
    wr_lo(8'hF0);
    wait_start();
    next_bit(); next_bit();
    tx_en = 0;
    @(negedge clk);
    chk(txd == 1'b1 && tend == 1'b1, "R11 abort idle", {txd, tend}, 2'b11);
    wr_lo(8'h00);
    repeat (16) @(negedge clk);
    chk(txd == 1'b1 && tend == 1'b1, "R11 disabled stays idle", {txd, tend}, 2'b11);

    finish_run();
  end
endmodule